// File: doc/BRIEF.md
# Approximate Low-Order Ripple Adder

This block adds two unsigned operands and a carry-in by rippling a carry through a row of one-bit cells. The lowest `LOW_BITS` positions use a cheap, deliberately inexact one-bit cell. The remaining upper positions use exact full adders. It is meant for pixel and filter arithmetic, where small errors in the low-order bits cannot be seen, and the saved gates and shorter carry path matter more than exactness.

The inexact cell is fixed at elaboration by `CELL_SEL`, which takes one of three variants:

- 1: the carry is exact and the sum is derived from it.
- 3: the carry is operand A passed straight through.
- 4: an AND/OR carry that drives a multiplexed sum.

The carry produced by the top inexact cell enters the first exact cell as an ordinary carry. An optional output register with a clock enable can be placed after the adder. The default build is a 16-bit adder made entirely of variant-1 cells, with the register present.

Top module: `aprx_ripple_adder`

## Requirements
- R1: With `CELL_SEL`=1, every inexact cell drives carry-out as the majority of A, B and carry-in, and drives sum as the inverse of that carry. Its result is wrong only for the inputs 000 and 111.
- R2: With `CELL_SEL`=3, every inexact cell forwards A as carry-out. Its sum is (B AND Cin) when A=1 and (B OR Cin) when A=0. The result is wrong only for the (A,B,Cin) inputs 011 and 100.
- R3: With `CELL_SEL`=4, every inexact cell drives carry-out as A AND (B OR Cin). Its sum is (B AND Cin) when that carry is 1 and (A OR B OR Cin) when it is 0. The result is wrong only for the input A=0, B=1, Cin=1.
- R4: Bit positions `LOW_BITS` to `WIDTH`-1 hold the exact sum of the upper operand bits plus the carry leaving bit `LOW_BITS`-1. The carry out of the top position appears on `cout_o`.
- R5: With `LOW_BITS`=0, {`cout_o`,`sum_o`} equals `a_i`+`b_i`+`cin_i` exactly, with `cin_i` entering bit 0.
- R6: With `CELL_SEL`=1, `cout_o` always equals the exact carry out of `a_i`+`b_i`+`cin_i`.
- R7: With `OUT_REG`=1 and `en`=1, the outputs show the result for the inputs present at a rising clock edge, starting just after that edge.
- R8: With `OUT_REG`=1 and `en`=0, `sum_o` and `cout_o` keep their previous values whatever the inputs do.
- R9: While `rst_n` is low, `sum_o` and `cout_o` are 0 regardless of the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| en | input | 1 | Clock enable of the output register |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum (approximate in the low region) |
| cout_o | output | 1 | Carry out of the top bit |

## Verification
The error cases of a cell only occur for one or two local input patterns. Those patterns must also coincide with particular carries arriving from the cells below, and the inexact carry then has to be seen leaving the low region and entering the exact one. Random operands reach these combinations only unevenly. The bench therefore runs four 8-bit instances in parallel: variant 1 across all bits, variant 3 in four low bits, variant 4 across all bits, and an exact build. It sweeps every operand pair with both carry-in values, so every local pattern meets every incoming carry at every position. A short phase before the sweep holds the enable low and changes the inputs, to show that the register keeps its value.

// File: rtl/aprx_add_pkg.sv
`timescale 1ns/1ps
package aprx_add_pkg;
  localparam int CELL_SUM_INV_CARRY = 1;
  localparam int CELL_A_FORWARD     = 3;
  localparam int CELL_ANDOR_MUX     = 4;

  function automatic bit cell_sel_valid(input int sel);
    return (sel == CELL_SUM_INV_CARRY) || (sel == CELL_A_FORWARD) ||
           (sel == CELL_ANDOR_MUX);
  endfunction
endpackage

// File: rtl/aprx_fa_cell.sv
`timescale 1ns/1ps
module aprx_fa_cell
  import aprx_add_pkg::*;
#(
  parameter int SEL = CELL_SUM_INV_CARRY
) (
  input  logic x_i,
  input  logic y_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  logic [1:0] exact_w;

  generate
    if (SEL == CELL_SUM_INV_CARRY) begin : g_v1
      always_comb begin
        c_o = (x_i & y_i) | (x_i & c_i) | (y_i & c_i);
        s_o = ~c_o;
      end
    end else if (SEL == CELL_A_FORWARD) begin : g_v3
      always_comb begin
        c_o = x_i;
        s_o = x_i ? (y_i & c_i) : (y_i | c_i);
      end
    end else begin : g_v4
      always_comb begin
        c_o = x_i & (y_i | c_i);
        s_o = c_o ? (y_i & c_i) : (x_i | y_i | c_i);
      end
    end
  endgenerate

  // error pattern of each variant, compared with true addition
  always_comb begin
    exact_w = {1'b0, x_i} + {1'b0, y_i} + {1'b0, c_i};
    if (SEL == CELL_SUM_INV_CARRY) begin
      a_r1_err_only_uniform: assert (({c_o, s_o} == exact_w) ||
        ((x_i == y_i) && (y_i == c_i)))
        else $error("variant 1 error outside 000/111");
    end else if (SEL == CELL_A_FORWARD) begin
      a_r2_err_two_cases: assert (({c_o, s_o} == exact_w) ||
        ({x_i, y_i, c_i} == 3'b011) || ({x_i, y_i, c_i} == 3'b100))
        else $error("variant 3 error outside 011/100");
    end else begin
      a_r3_err_one_case: assert (({c_o, s_o} == exact_w) ||
        ({x_i, y_i, c_i} == 3'b011))
        else $error("variant 4 error outside 011");
    end
  end
endmodule

// File: rtl/exact_fa_cell.sv
`timescale 1ns/1ps
module exact_fa_cell (
  input  logic x_i,
  input  logic y_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  logic p_w;
  always_comb begin
    p_w = x_i ^ y_i;
    s_o = p_w ^ c_i;
    c_o = (x_i & y_i) | (p_w & c_i);
  end
endmodule

// File: rtl/aprx_out_stage.sv
`timescale 1ns/1ps
module aprx_out_stage #(
  parameter int W   = 17,
  parameter bit REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  generate
    if (REG) begin : g_reg
      logic [W-1:0] q_r;
      logic [W-1:0] q_nxt;

      always_comb begin
        q_nxt = q_r;
        if (en) q_nxt = d_i;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_r <= '0;
        else        q_r <= q_nxt;
      end

      assign q_o = q_r;

      a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(q_o))
        else $error("output changed while enable low");
    end else begin : g_wire
      assign q_o = d_i;
    end
  endgenerate
endmodule

// File: rtl/aprx_ripple_adder.sv
`timescale 1ns/1ps
module aprx_ripple_adder
  import aprx_add_pkg::*;
#(
  parameter int WIDTH    = 16,
  parameter int LOW_BITS = 16,
  parameter int CELL_SEL = CELL_SUM_INV_CARRY,
  parameter bit OUT_REG  = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  localparam int HI_BITS = WIDTH - LOW_BITS;

  generate
    if (!cell_sel_valid(CELL_SEL)) begin : g_bad_sel
      $error("CELL_SEL must be 1, 3 or 4");
    end
    if (LOW_BITS < 0 || LOW_BITS > WIDTH) begin : g_bad_low
      $error("LOW_BITS must lie in 0..WIDTH");
    end
  endgenerate

  logic [WIDTH:0]   cy;
  logic [WIDTH-1:0] raw_sum;

  assign cy[0] = cin_i;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if (i < LOW_BITS) begin : g_apx
        aprx_fa_cell #(.SEL(CELL_SEL)) u_cell (
          .x_i(a_i[i]), .y_i(b_i[i]), .c_i(cy[i]),
          .s_o(raw_sum[i]), .c_o(cy[i+1])
        );
      end else begin : g_exa
        exact_fa_cell u_cell (
          .x_i(a_i[i]), .y_i(b_i[i]), .c_i(cy[i]),
          .s_o(raw_sum[i]), .c_o(cy[i+1])
        );
      end
    end
  endgenerate

  logic [WIDTH:0] out_w;

  aprx_out_stage #(.W(WIDTH + 1), .REG(OUT_REG)) u_out (
    .clk(clk), .rst_n(rst_n), .en(en),
    .d_i({cy[WIDTH], raw_sum}), .q_o(out_w)
  );

  assign sum_o  = out_w[WIDTH-1:0];
  assign cout_o = out_w[WIDTH];

  // cross-checks of the chain against word-level arithmetic
  generate
    if (HI_BITS > 0 && LOW_BITS > 0) begin : g_chk_hi
      logic [HI_BITS:0] hi_ref;
      always_comb begin
        hi_ref = {1'b0, a_i[WIDTH-1:LOW_BITS]} + {1'b0, b_i[WIDTH-1:LOW_BITS]}
               + {{HI_BITS{1'b0}}, cy[LOW_BITS]};
        a_r4_upper_exact: assert (hi_ref == {cy[WIDTH], raw_sum[WIDTH-1:LOW_BITS]})
          else $error("upper region not exact");
      end
    end
    if (LOW_BITS == 0) begin : g_chk_exact
      logic [WIDTH:0] full_ref;
      always_comb begin
        full_ref = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};
        a_r5_all_exact: assert (full_ref == {cy[WIDTH], raw_sum})
          else $error("exact build mismatch");
      end
    end
    if (LOW_BITS > 0 && CELL_SEL == CELL_SUM_INV_CARRY) begin : g_chk_v1
      logic [LOW_BITS:0] lo_ref;
      always_comb begin
        lo_ref = {1'b0, a_i[LOW_BITS-1:0]} + {1'b0, b_i[LOW_BITS-1:0]}
               + {{LOW_BITS{1'b0}}, cin_i};
        a_r6_carry_exact: assert (lo_ref[LOW_BITS] == cy[LOW_BITS])
          else $error("variant 1 boundary carry inexact");
      end
    end
    if (LOW_BITS > 0 && CELL_SEL == CELL_A_FORWARD) begin : g_chk_v3
      always_comb begin
        a_r2_boundary_is_a: assert (cy[LOW_BITS] == a_i[LOW_BITS-1])
          else $error("variant 3 boundary carry not operand bit");
      end
    end
  endgenerate
endmodule

// File: tb/tb_aprx_ripple_adder.sv
`timescale 1ns/1ps
module tb_aprx_ripple_adder;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic ci = 1'b0;

  always #2.5 clk = ~clk;

  logic [W-1:0] s1, s3, s4, s0;
  logic c1, c3, c4, c0;

  aprx_ripple_adder #(.WIDTH(W), .LOW_BITS(8), .CELL_SEL(1), .OUT_REG(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .a_i(a), .b_i(b), .cin_i(ci),
    .sum_o(s1), .cout_o(c1));
  aprx_ripple_adder #(.WIDTH(W), .LOW_BITS(4), .CELL_SEL(3), .OUT_REG(1'b1)) dut_v3 (
    .clk(clk), .rst_n(rst_n), .en(en), .a_i(a), .b_i(b), .cin_i(ci),
    .sum_o(s3), .cout_o(c3));
  aprx_ripple_adder #(.WIDTH(W), .LOW_BITS(8), .CELL_SEL(4), .OUT_REG(1'b1)) dut_v4 (
    .clk(clk), .rst_n(rst_n), .en(en), .a_i(a), .b_i(b), .cin_i(ci),
    .sum_o(s4), .cout_o(c4));
  aprx_ripple_adder #(.WIDTH(W), .LOW_BITS(0), .CELL_SEL(1), .OUT_REG(1'b1)) dut_ex (
    .clk(clk), .rst_n(rst_n), .en(en), .a_i(a), .b_i(b), .cin_i(ci),
    .sum_o(s0), .cout_o(c0));

  int n_cmp = 0;
  int n_bad = 0;
  bit mon_on = 1'b0;

  // behavioural model written from the cell equations in the requirements
  function automatic logic [W:0] model(input logic [W-1:0] x, input logic [W-1:0] y,
                                       input logic cin, input int low, input int sel);
    logic c;
    logic [W-1:0] s;
    c = cin;
    for (int i = 0; i < W; i++) begin
      logic co;
      if (i < low && sel == 1) begin
        co = (x[i] & y[i]) | (x[i] & c) | (y[i] & c);
        s[i] = ~co;
      end else if (i < low && sel == 3) begin
        co = x[i];
        s[i] = x[i] ? (y[i] & c) : (y[i] | c);
      end else if (i < low && sel == 4) begin
        co = x[i] & (y[i] | c);
        s[i] = co ? (y[i] & c) : (x[i] | y[i] | c);
      end else begin
        co = (x[i] & y[i]) | (x[i] & c) | (y[i] & c);
        s[i] = x[i] ^ y[i] ^ c;
      end
      c = co;
    end
    return {c, s};
  endfunction

  typedef struct packed {
    logic [W:0] e1;
    logic [W:0] e3;
    logic [W:0] e4;
    logic [W:0] e0;
    logic       ex_c;
  } item_t;

  item_t sb[$];

  task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (a=%h b=%h ci=%b)", req, act, exp, a, b, ci);
    end
  endtask

  task automatic push(input logic [W-1:0] x, input logic [W-1:0] y, input logic cin);
    item_t it;
    logic [W:0] ex;
    @(negedge clk);
    a = x; b = y; ci = cin;
    ex = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
    it.e1 = model(x, y, cin, 8, 1);
    it.e3 = model(x, y, cin, 4, 3);
    it.e4 = model(x, y, cin, 8, 4);
    it.e0 = ex;
    it.ex_c = ex[W];
    sb.push_back(it);
  endtask

  // monitor: one registered result per cycle, sampled 1 ns after the edge
  always @(posedge clk) begin
    item_t got;
    #1;
    if (mon_on && sb.size() > 0) begin
      got = sb.pop_front();
      check("R1", {c1, s1}, got.e1);
      check("R2,R4", {c3, s3}, got.e3);
      check("R3", {c4, s4}, got.e4);
      check("R5", {c0, s0}, got.e0);
      check("R6", {{W{1'b0}}, c1}, {{W{1'b0}}, got.ex_c});
    end
  end

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R9: reset dominates inputs and enable
    a = 8'hFF; b = 8'h01; ci = 1'b1; en = 1'b1;
    repeat (3) @(negedge clk);
    check("R9", {c1, s1}, '0);
    check("R9", {c3, s3}, '0);
    check("R9", {c0, s0}, '0);

    // R8: released from reset but enable low, outputs stay 0
    en = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    a = 8'hA5; b = 8'h3C; ci = 1'b1;
    repeat (2) @(negedge clk);
    check("R8", {c1, s1}, '0);
    check("R8", {c4, s4}, '0);

    // R7: one edge with enable high captures the result
    en = 1'b1;
    a = 8'h7E; b = 8'h19; ci = 1'b0;
    @(negedge clk);
    check("R7", {c0, s0}, 9'h097);
    check("R7", {c4, s4}, model(8'h7E, 8'h19, 1'b0, 8, 4));

    // R8: enable low with new inputs, previous result held
    en = 1'b0;
    a = 8'h01; b = 8'hFF; ci = 1'b1;
    repeat (2) @(negedge clk);
    check("R8", {c0, s0}, 9'h097);
    check("R8", {c3, s3}, model(8'h7E, 8'h19, 1'b0, 4, 3));

    // exhaustive sweep through the scoreboard
    en = 1'b1;
    mon_on = 1'b1;
    for (int x = 0; x < 256; x++) begin
      for (int y = 0; y < 256; y++) begin
        for (int k = 0; k < 2; k++) begin
          push(x[W-1:0], y[W-1:0], k[0]);
        end
      end
    end
    repeat (3) @(negedge clk);
    mon_on = 1'b0;
    if (sb.size() != 0) begin
      n_bad++;
      $display("FAIL R7: actual %0d pending expected 0", sb.size());
    end
    finish_run();
  end
endmodule